// File: doc/BRIEF.md
# Return Address Stack Controller

This block keeps the return addresses of a small microcontroller core in an eight-entry hardware stack. The current program counter is saved when a subroutine call executes or when an interrupt is acknowledged. A return or return-from-interrupt strobe restores the most recently saved value. The restored address comes out one cycle after the strobe, together with a pop-valid pulse.

The block also decides when an interrupt may be acknowledged. An unmasked request sets a pending flag. The acknowledge is a one-cycle pulse, and it is held back while the stack is full, so an interrupt can never overflow the stack. A subroutine call behaves differently: on a full stack it still pushes, and the oldest saved address is lost. Instruction decode, vector generation and the program counter register are outside this block.

The write slot is a circular index. A separate occupancy count from 0 to the depth is kept beside it, so that a full stack and an empty stack can be told apart after the index wraps.

Top module: `ras_ctrl`

## Requirements
- R1: After reset the stack is empty. `full_o`, `irq_pend_o`, `irq_ack_o`, `pop_valid_o` and `underflow_o` are all 0, and every entry holds 0.
- R2: A cycle with `call_i`=1 pushes `pc_i`. A pop on a non-empty stack drives the top entry on `ret_addr_o` in the next cycle, with a one-cycle `pop_valid_o` pulse. Entries come back last-in first-out.
- R3: The stack holds at most 8 entries. `full_o` is 1 exactly when 8 entries are held.
- R4: A call made while the stack is full still pushes. The oldest entry is overwritten and the occupancy stays at 8.
- R5: A request with `irq_req_i`=1 and `irq_mask_i`=0 sets `irq_pend_o` from the next cycle. A request with `irq_mask_i`=1 leaves the pending flag and the acknowledge unchanged.
- R6: `irq_ack_o` is 1 in a cycle exactly when the pending flag is set, the stack is not full, and neither a pop nor a call is requested in that cycle. The acknowledge pushes `pc_i`. The pending flag clears in the next cycle unless an unmasked request arrives in the same cycle as the acknowledge.
- R7: While the stack is full, `irq_ack_o` stays 0 and a pending request stays pending.
- R8: When a push and a pop are requested in the same cycle, only the pop happens. An interrupt held back by a full stack is acknowledged no earlier than the cycle after the pop that frees a slot.
- R9: A pop on an empty stack leaves the pointer and occupancy unchanged. In the next cycle it drives the entry just below the write slot on `ret_addr_o`, with `underflow_o`=1 for one cycle and `pop_valid_o`=0.
- R10: `reti_i` pops exactly as `ret_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_i | input | 1 | Interrupt request |
| irq_mask_i | input | 1 | 1 blocks the request |
| pc_i | input | PC_W | Current program counter |
| ret_addr_o | output | PC_W | Restored return address |
| pop_valid_o | output | 1 | Pulse: ret_addr_o holds a popped entry |
| irq_ack_o | output | 1 | Single-cycle interrupt acknowledge |
| irq_pend_o | output | 1 | Interrupt pending flag |
| full_o | output | 1 | Stack holds the full depth |
| underflow_o | output | 1 | Pulse: the last pop found the stack empty |

## Verification
The bench sweeps the number of calls from 0 to 11 and then drains the stack with one pop more than it holds. Counts below the depth show plain LIFO order. Counts above it show that the oldest entries are lost, and the extra pop shows underflow. Returns alternate between `ret_i` and `reti_i`.

Interrupt patterns cover four cases: a request on a full stack held until a return, a masked request, a request that collides with a call, and a call made together with a return. Together they separate the acknowledge gating from the push and pop priority. A cycle-level model in the bench compares every output on every cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctl.sv
module ras_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ras_pkg::ras_op_e  op,
  output logic [PW-1:0]     wr_idx,
  output logic [PW-1:0]     top_idx,
  output logic [CW-1:0]     occ,
  output logic              empty,
  output logic              full
);
  import ras_pkg::*;

  function automatic logic [PW-1:0] idx_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] idx_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  // occupancy saturates at DEPTH on push and holds at 0 on pop
  function automatic logic [CW-1:0] occ_next(input logic [CW-1:0] c, input ras_op_e o);
    case (o)
      OP_PUSH: return (c == CW'(DEPTH)) ? c : c + CW'(1);
      OP_POP:  return (c == '0) ? c : c - CW'(1);
      default: return c;
    endcase
  endfunction

  logic [PW-1:0] wp_q;
  logic [CW-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (op == OP_PUSH)
        wp_q <= idx_inc(wp_q);
      else if (op == OP_POP && occ_q != '0)
        wp_q <= idx_dec(wp_q);
      occ_q <= occ_next(occ_q, op);
    end
  end

  assign wr_idx  = wp_q;
  assign top_idx = idx_dec(wp_q);
  assign occ     = occ_q;
  assign empty   = (occ_q == '0);
  assign full    = (occ_q == CW'(DEPTH));
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [PC_W-1:0] wdata,
  input  logic            re,
  input  logic [PW-1:0]   raddr,
  output logic [PC_W-1:0] rdata
);
  logic [PC_W-1:0] slot [DEPTH];
  logic [PC_W-1:0] rdata_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (we && waddr == PW'(g))
        slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (re)
      rdata_q <= slot[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mask,
  input  logic stack_full,
  input  logic pop_req,
  input  logic call_req,
  output logic ack,
  output logic pend
);
  logic pend_q;
  logic req_live;

  assign req_live = req && !mask;
  assign ack      = pend_q && !stack_full && !pop_req && !call_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else
      pend_q <= (pend_q && !ack) || req_live;
  end

  assign pend = pend_q;
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            irq_req_i,
  input  logic            irq_mask_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_addr_o,
  output logic            pop_valid_o,
  output logic            irq_ack_o,
  output logic            irq_pend_o,
  output logic            full_o,
  output logic            underflow_o
);
  import ras_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events
  logic          pop_evt;
  logic          push_evt;
  logic          ack_evt;
  logic          pop_empty_evt;
  logic          stk_full;
  logic          stk_empty;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] top_idx;
  logic [CW-1:0] occ;
  ras_op_e       op;
  logic          pop_valid_q;
  logic          underflow_q;

  assign pop_evt       = ret_i || reti_i;
  assign push_evt      = !pop_evt && (call_i || ack_evt);
  assign pop_empty_evt = pop_evt && stk_empty;
  assign op            = pop_evt ? OP_POP : (push_evt ? OP_PUSH : OP_IDLE);

  ras_irq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (irq_req_i),
    .mask       (irq_mask_i),
    .stack_full (stk_full),
    .pop_req    (pop_evt),
    .call_req   (call_i),
    .ack        (ack_evt),
    .pend       (irq_pend_o)
  );

  ras_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wr_idx  (wr_idx),
    .top_idx (top_idx),
    .occ     (occ),
    .empty   (stk_empty),
    .full    (stk_full)
  );

  ras_mem #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (push_evt),
    .waddr (wr_idx),
    .wdata (pc_i),
    .re    (pop_evt),
    .raddr (top_idx),
    .rdata (ret_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid_q <= 1'b0;
      underflow_q <= 1'b0;
    end else begin
      pop_valid_q <= pop_evt && !stk_empty;
      underflow_q <= pop_empty_evt;
    end
  end

  assign pop_valid_o = pop_valid_q;
  assign underflow_o = underflow_q;
  assign irq_ack_o   = ack_evt;
  assign full_o      = stk_full;
endmodule

// File: rtl/ras_ctrl_chk.sv
module ras_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          irq_req_i,
  input logic          irq_mask_i,
  input logic          pop_evt,
  input logic          irq_ack_o,
  input logic          irq_pend_o,
  input logic          full_o,
  input logic          stk_empty,
  input logic          pop_valid_o,
  input logic          underflow_o,
  input logic [CW-1:0] occ
);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R4
  full_call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && call_i && !pop_evt) |=> full_o);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);
  // R7
  full_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && irq_pend_o && !pop_evt) |=> irq_pend_o);
  // R8
  pop_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> !irq_ack_o);
  // R6
  ack_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> irq_pend_o);
  // R6
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && !(irq_req_i && !irq_mask_i)) |=> !irq_pend_o);
  // R5
  req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_i && !irq_mask_i) |=> irq_pend_o);
  // R2
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !stk_empty) |=> (pop_valid_o && !underflow_o));
  // R9
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && stk_empty) |=> (underflow_o && !pop_valid_o));
endmodule

bind ras_ctrl ras_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_i      (call_i),
  .irq_req_i   (irq_req_i),
  .irq_mask_i  (irq_mask_i),
  .pop_evt     (pop_evt),
  .irq_ack_o   (irq_ack_o),
  .irq_pend_o  (irq_pend_o),
  .full_o      (full_o),
  .stk_empty   (stk_empty),
  .pop_valid_o (pop_valid_o),
  .underflow_o (underflow_o),
  .occ         (occ)
);

// File: tb/ras_ctrl_tb.sv
module ras_ctrl_tb;
  localparam int D  = 8;
  localparam int PW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, reti_i = 0, irq_req_i = 0, irq_mask_i = 0;
  logic [PW-1:0] pc_i = '0;
  logic [PW-1:0] ret_addr_o;
  logic pop_valid_o, irq_ack_o, irq_pend_o, full_o, underflow_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  int m_slot [D];
  int m_wp, m_cnt;
  bit m_pend;
  int m_addr;
  bit m_valid, m_uf;

  always #5 clk = ~clk;

  ras_ctrl #(.DEPTH(D), .PC_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i),
    .irq_req_i(irq_req_i), .irq_mask_i(irq_mask_i), .pc_i(pc_i),
    .ret_addr_o(ret_addr_o), .pop_valid_o(pop_valid_o), .irq_ack_o(irq_ack_o),
    .irq_pend_o(irq_pend_o), .full_o(full_o), .underflow_o(underflow_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {call_i, ret_i, reti_i, irq_req_i, irq_mask_i} = '0;
    pc_i = '0;
    for (int i = 0; i < D; i++) m_slot[i] = 0;
    m_wp = 0; m_cnt = 0; m_pend = 0; m_addr = 0; m_valid = 0; m_uf = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one cycle: drive, sample the acknowledge before the edge, then compare registered outputs
  task automatic step(input bit c, input bit r, input bit ri, input bit q, input bit mk, input int pc);
    bit exp_ack, ack_seen, pop;
    @(negedge clk);
    call_i = c; ret_i = r; reti_i = ri; irq_req_i = q; irq_mask_i = mk; pc_i = PW'(pc);
    #1;
    ack_seen = irq_ack_o;
    pop = r || ri;
    exp_ack = m_pend && (m_cnt < D) && !pop && !c;
    check("R6/R7/R8 ack", int'(ack_seen), int'(exp_ack));
    m_valid = 0; m_uf = 0;
    if (pop) begin
      m_addr = m_slot[(m_wp + D - 1) % D];
      if (m_cnt > 0) begin
        m_wp = (m_wp + D - 1) % D; m_cnt--; m_valid = 1;
      end else m_uf = 1;
    end else if (c || exp_ack) begin
      m_slot[m_wp] = pc % (1 << PW);
      m_wp = (m_wp + 1) % D;
      if (m_cnt < D) m_cnt++;
    end
    m_pend = (m_pend && !exp_ack) || (q && !mk);
    @(posedge clk); #1;
    call_i = 0; ret_i = 0; reti_i = 0; irq_req_i = 0;
    check("R2 pop_valid", int'(pop_valid_o), int'(m_valid));
    check("R9 underflow", int'(underflow_o), int'(m_uf));
    check("R3 full", int'(full_o), int'(m_cnt == D));
    check("R5 pend", int'(irq_pend_o), int'(m_pend));
    if (pop) begin
      if (r) check("R2 ret_addr", int'(ret_addr_o), m_addr);
      else   check("R10 ret_addr", int'(ret_addr_o), m_addr);
    end
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 full", int'(full_o), 0);
    check("R1 pend", int'(irq_pend_o), 0);
    check("R1 ack", int'(irq_ack_o), 0);
    check("R1 pop_valid", int'(pop_valid_o), 0);
    check("R1 underflow", int'(underflow_o), 0);
    // R9: pop on empty after reset returns zero
    step(0, 1, 0, 0, 0, 0);
    check("R9 R1 zero entry", int'(ret_addr_o), 0);

    // R2 R3 R4 R9 R10: call-count sweep, drain with one extra pop
    for (int n = 0; n <= 11; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 300 * n + 7 * i + 1);
      for (int j = 0; j <= ((n < D) ? n : D); j++) step(0, j % 2 == 0, j % 2 == 1, 0, 0, 0);
    end

    // R7 R8: full stack holds a request until a return frees a slot
    do_reset();
    for (int i = 0; i < D; i++) step(1, 0, 0, 0, 0, 40 + i);
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 900 + i);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1234);
    step(0, 0, 1, 0, 0, 0);
    check("R6 pushed pc on ack", int'(ret_addr_o), 1234);

    // R5: masked request is ignored
    do_reset();
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 55);
    check("R5 masked no pend", int'(irq_pend_o), 0);

    // R6 R8: call wins over ack; call+ret together only pops
    do_reset();
    step(1, 0, 0, 0, 0, 11);
    step(1, 0, 0, 0, 0, 22);
    step(0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 33);
    step(0, 0, 0, 0, 0, 44);
    step(1, 1, 0, 0, 0, 66);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    // R6: request during ack keeps pend
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 77);
    step(0, 0, 0, 0, 0, 88);
    step(0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule